// File: doc/BRIEF.md
# DMA Transfer Count and Length Unit

This block keeps the 24-bit byte counter that software programs before a DMA transfer of a SCSI host adapter. The counter is written one byte at a time into a write-side copy, and a command carrying the DMA flag copies that value into the read-side counter that the rest of the adapter sees. When a transfer command starts, the unit works out how many bytes are actually granted. A programmed count of zero stands for 65536 bytes. The count is then limited by the size of the data the target still has pending, or by 32 while command bytes are being captured. The sign of the pending size gives the direction.

While a transfer runs, the unit counts down the bytes remaining as chunks are accepted. It ends the transfer when the count is used up, or earlier when a chunk reports a partly filled buffer. At the end it sets the terminal-count status, clears the read-side counter and emits a one-cycle done pulse, which the interrupt logic uses. A transfer command that arrives while the DMA channel is not yet enabled is held, and it starts when the enable input rises. The memory traffic itself lives outside this block.

Top module: `dma_count_unit`

## Requirements
- R1: After reset, count_rd, dma_len and remaining are 0, and tc_status, dma_mode, xfer_busy, xfer_held and done_pulse are all 0.
- R2: A write with cnt_we loads byte cnt_sel of the write-side count. Select 0 is bits 7:0, 1 is bits 15:8 and 2 is bits 23:16. The write leaves count_rd unchanged and clears tc_status at the next edge.
- R3: A command (cmd_valid) with cmd_dma=1 copies the write-side count into count_rd and sets dma_mode. With cmd_dma=0 it clears dma_mode and leaves count_rd unchanged.
- R4: When a transfer starts, a count of zero is taken as 65536.
- R5: Outside capture mode, dma_len = min(count, |pend_size|). to_device is 1 exactly when pend_size is negative.
- R6: With capture_mode=1, dma_len = min(count, 32) regardless of pend_size.
- R7: A transfer start, caused by cmd_valid with cmd_xfer=1, cmd_dma=1 and dma_enable=1, sets xfer_busy, loads remaining with dma_len and clears tc_status, all one cycle after the command.
- R8: Each chunk_valid cycle during a transfer lowers remaining by chunk_len.
- R9: When a chunk empties remaining, done_pulse is 1 for one cycle. In the same cycle tc_status is 1, count_rd is 0 and xfer_busy is 0.
- R10: A chunk with chunk_short=1 ends the transfer at once. remaining keeps the bytes not moved, and done_pulse, tc_status and the cleared count_rd follow as in R9.
- R11: A transfer command with the DMA flag sent while dma_enable=0 sets xfer_held without starting. The transfer starts on the rising edge of dma_enable, using pend_size and capture_mode as they are at that edge.
- R12: A transfer command with cmd_dma=0 starts no transfer. xfer_busy stays 0 and dma_len is unchanged.
- R13: A start whose granted length is 0 finishes immediately. done_pulse and tc_status are 1 one cycle later, with dma_len 0 and xfer_busy 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_we | input | 1 | Count byte write strobe |
| cnt_sel | input | 2 | Count byte select (0 low, 1 middle, 2 high) |
| cnt_wdata | input | 8 | Count byte write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| cmd_xfer | input | 1 | Command is a transfer-information command |
| pend_size | input | 25 | Signed pending transfer size (negative: toward device) |
| capture_mode | input | 1 | Command bytes are being captured |
| dma_enable | input | 1 | DMA channel enable level |
| chunk_valid | input | 1 | A chunk of data was accepted |
| chunk_len | input | 25 | Byte length of the accepted chunk |
| chunk_short | input | 1 | Chunk came from a partly filled buffer |
| dma_mode | output | 1 | Last command carried the DMA flag |
| count_rd | output | 24 | Read-side transfer count |
| dma_len | output | 25 | Granted DMA length of the last start |
| remaining | output | 25 | Bytes still to move |
| to_device | output | 1 | Direction of the last start |
| xfer_busy | output | 1 | Transfer running |
| xfer_held | output | 1 | Transfer command waiting for enable |
| tc_status | output | 1 | Terminal-count status |
| done_pulse | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The length grant is tried with four patterns. A small positive pending size below the count shows that the limit comes from the pending data. A zero count with a large negative pending size separates the 65536 substitute and the direction flag from a plain 24-bit count. Capture mode is tried with counts above and below 32, which shows the cap is a minimum and not a fixed value. A zero pending size shows a zero grant finishing at once. The end of a transfer is reached both by exact countdown and by a short chunk, and a command held for enable is started with a pending size changed in the meantime, which confirms that the size at the enable edge is the one used.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_HELD = 2'd1,
    TRK_RUN  = 2'd2
  } trk_state_e;
endpackage

// File: rtl/dma_cnt_regs.sv
module dma_cnt_regs #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  localparam int CNT_W = BYTE_W * NBYTES,
  localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic             load,
  input  logic             clr,
  output logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] rd_val
);
  logic [CNT_W-1:0] wr_q;
  logic [CNT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (we) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (sel == SEL_W'(i)) wr_q[i*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rd_q <= '0;
    else if (clr)  rd_q <= '0;
    else if (load) rd_q <= wr_q;
  end

  assign wr_val = wr_q;
  assign rd_val = rd_q;
endmodule

// File: rtl/dma_len_calc.sv
module dma_len_calc #(
  parameter int CNT_W    = 24,
  parameter int LEN_W    = 25,
  parameter int PEND_W   = 25,
  parameter int CAP_LEN  = 32,
  parameter int ZERO_LEN = 65536
) (
  input  logic [CNT_W-1:0]         count,
  input  logic signed [PEND_W-1:0] pend,
  input  logic                     capture,
  output logic [LEN_W-1:0]         grant
);
  function automatic logic [LEN_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? LEN_W'(ZERO_LEN) : LEN_W'(c);
  endfunction

  function automatic logic [LEN_W-1:0] magnitude(input logic signed [PEND_W-1:0] p);
    logic [PEND_W-1:0] u;
    u = p[PEND_W-1] ? (~p + 1'b1) : p;
    return LEN_W'(u);
  endfunction

  function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  always_comb begin
    if (capture) grant = min_len(eff_count(count), LEN_W'(CAP_LEN));
    else         grant = min_len(eff_count(count), magnitude(pend));
  end
endmodule

// File: rtl/dma_xfer_tracker.sv
module dma_xfer_tracker
  import dma_cnt_pkg::*;
#(
  parameter int LEN_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic             dma_enable,
  input  logic [LEN_W-1:0] grant,
  input  logic             pend_neg,
  input  logic             chunk_valid,
  input  logic [LEN_W-1:0] chunk_len,
  input  logic             chunk_short,
  output logic [LEN_W-1:0] dma_len,
  output logic [LEN_W-1:0] remaining,
  output logic             to_device,
  output logic             busy,
  output logic             held,
  output logic             start_evt,
  output logic             finish_evt,
  output logic             done_pulse
);
  trk_state_e      state;
  logic            en_q;
  logic            en_rise;
  logic            hold_evt;
  logic            chunk_evt;
  logic [LEN_W-1:0] take;

  assign en_rise   = dma_enable & ~en_q;
  assign start_evt = (cmd_go & dma_enable) | ((state == TRK_HELD) & en_rise & ~cmd_go);
  assign hold_evt  = cmd_go & ~dma_enable;
  assign chunk_evt = (state == TRK_RUN) & chunk_valid & ~cmd_go;
  assign take      = (chunk_len < remaining) ? chunk_len : remaining;
  assign finish_evt = (start_evt & (grant == '0)) |
                      (chunk_evt & ((chunk_len >= remaining) | chunk_short));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= TRK_IDLE;
      en_q       <= 1'b0;
      dma_len    <= '0;
      remaining  <= '0;
      to_device  <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      en_q       <= dma_enable;
      done_pulse <= finish_evt;
      if (start_evt) begin
        dma_len   <= grant;
        remaining <= grant;
        to_device <= pend_neg;
        state     <= (grant == '0) ? TRK_IDLE : TRK_RUN;
      end else if (hold_evt) begin
        state <= TRK_HELD;
      end else if (chunk_evt) begin
        remaining <= remaining - take;
        if (finish_evt) state <= TRK_IDLE;
      end
    end
  end

  assign busy = (state == TRK_RUN);
  assign held = (state == TRK_HELD);
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int BYTE_W   = 8,
  parameter int NBYTES   = 3,
  parameter int CAP_LEN  = 32,
  parameter int ZERO_LEN = 65536,
  localparam int CNT_W   = BYTE_W * NBYTES,
  localparam int LEN_W   = CNT_W + 1,
  localparam int PEND_W  = LEN_W,
  localparam int SEL_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cnt_we,
  input  logic [SEL_W-1:0]         cnt_sel,
  input  logic [BYTE_W-1:0]        cnt_wdata,
  input  logic                     cmd_valid,
  input  logic                     cmd_dma,
  input  logic                     cmd_xfer,
  input  logic signed [PEND_W-1:0] pend_size,
  input  logic                     capture_mode,
  input  logic                     dma_enable,
  input  logic                     chunk_valid,
  input  logic [LEN_W-1:0]         chunk_len,
  input  logic                     chunk_short,
  output logic                     dma_mode,
  output logic [CNT_W-1:0]         count_rd,
  output logic [LEN_W-1:0]         dma_len,
  output logic [LEN_W-1:0]         remaining,
  output logic                     to_device,
  output logic                     xfer_busy,
  output logic                     xfer_held,
  output logic                     tc_status,
  output logic                     done_pulse
);
  logic [CNT_W-1:0] wr_val;
  logic [CNT_W-1:0] rd_val;
  logic [CNT_W-1:0] start_cnt;
  logic [LEN_W-1:0] grant;
  logic             cmd_go;
  logic             reload_evt;
  logic             start_evt;
  logic             finish_evt;

  assign cmd_go     = cmd_valid & cmd_xfer & cmd_dma;
  assign reload_evt = cmd_valid & cmd_dma;
  // A direct command uses the value being copied in this same cycle.
  assign start_cnt  = cmd_go ? wr_val : rd_val;

  dma_cnt_regs #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cnt_we), .sel(cnt_sel), .wdata(cnt_wdata),
    .load(reload_evt), .clr(finish_evt), .wr_val(wr_val), .rd_val(rd_val)
  );

  dma_len_calc #(.CNT_W(CNT_W), .LEN_W(LEN_W), .PEND_W(PEND_W),
                 .CAP_LEN(CAP_LEN), .ZERO_LEN(ZERO_LEN)) u_calc (
    .count(start_cnt), .pend(pend_size), .capture(capture_mode), .grant(grant)
  );

  dma_xfer_tracker #(.LEN_W(LEN_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .dma_enable(dma_enable),
    .grant(grant), .pend_neg(pend_size[PEND_W-1]), .chunk_valid(chunk_valid),
    .chunk_len(chunk_len), .chunk_short(chunk_short), .dma_len(dma_len),
    .remaining(remaining), .to_device(to_device), .busy(xfer_busy),
    .held(xfer_held), .start_evt(start_evt), .finish_evt(finish_evt),
    .done_pulse(done_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_mode  <= 1'b0;
      tc_status <= 1'b0;
    end else begin
      if (cmd_valid) dma_mode <= cmd_dma;
      if (finish_evt)                tc_status <= 1'b1;
      else if (start_evt || cnt_we)  tc_status <= 1'b0;
    end
  end

  assign count_rd = rd_val;
endmodule

// File: rtl/dma_count_unit_chk.sv
module dma_count_unit_chk #(
  parameter int CNT_W   = 24,
  parameter int LEN_W   = 25,
  parameter int CAP_LEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_we,
  input logic             cmd_valid,
  input logic             cmd_dma,
  input logic             capture_mode,
  input logic             dma_enable,
  input logic             tc_status,
  input logic             done_pulse,
  input logic             dma_mode,
  input logic             xfer_busy,
  input logic             xfer_held,
  input logic [CNT_W-1:0] count_rd,
  input logic [CNT_W-1:0] wr_val,
  input logic [LEN_W-1:0] dma_len,
  input logic [LEN_W-1:0] remaining,
  input logic             start_evt,
  input logic             finish_evt
);
  p_write_clears_tc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we && !finish_evt |=> !tc_status);

  p_reload_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_dma && !finish_evt |=> count_rd == $past(wr_val));

  p_dma_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_dma |=> !dma_mode);

  p_capture_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && capture_mode |=> dma_len <= LEN_W'(CAP_LEN));

  p_start_clears_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !finish_evt |=> !tc_status && xfer_busy);

  p_remaining_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> remaining <= dma_len);

  p_done_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> tc_status && count_rd == '0 && !xfer_busy);

  p_held_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_held && !dma_enable && !cmd_valid |=> xfer_held);
endmodule

bind dma_count_unit dma_count_unit_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W), .CAP_LEN(CAP_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cmd_valid(cmd_valid),
  .cmd_dma(cmd_dma), .capture_mode(capture_mode), .dma_enable(dma_enable),
  .tc_status(tc_status), .done_pulse(done_pulse), .dma_mode(dma_mode),
  .xfer_busy(xfer_busy), .xfer_held(xfer_held), .count_rd(count_rd),
  .wr_val(wr_val), .dma_len(dma_len), .remaining(remaining),
  .start_evt(start_evt), .finish_evt(finish_evt)
);

// File: tb/dma_count_unit_bench.sv
module dma_count_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_we;
  logic [1:0]  cnt_sel;
  logic [7:0]  cnt_wdata;
  logic        cmd_valid, cmd_dma, cmd_xfer;
  logic signed [24:0] pend_size;
  logic        capture_mode, dma_enable;
  logic        chunk_valid;
  logic [24:0] chunk_len;
  logic        chunk_short;
  logic        dma_mode;
  logic [23:0] count_rd;
  logic [24:0] dma_len, remaining;
  logic        to_device, xfer_busy, xfer_held, tc_status, done_pulse;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  dma_count_unit u_dma_count_unit (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_sel(cnt_sel),
    .cnt_wdata(cnt_wdata), .cmd_valid(cmd_valid), .cmd_dma(cmd_dma),
    .cmd_xfer(cmd_xfer), .pend_size(pend_size), .capture_mode(capture_mode),
    .dma_enable(dma_enable), .chunk_valid(chunk_valid), .chunk_len(chunk_len),
    .chunk_short(chunk_short), .dma_mode(dma_mode), .count_rd(count_rd),
    .dma_len(dma_len), .remaining(remaining), .to_device(to_device),
    .xfer_busy(xfer_busy), .xfer_held(xfer_held), .tc_status(tc_status),
    .done_pulse(done_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [1:0] sel, input logic [7:0] val);
    cnt_we = 1'b1; cnt_sel = sel; cnt_wdata = val;
    tick();
    cnt_we = 1'b0;
  endtask

  task automatic send_cmd(input logic dma, input logic xfer);
    cmd_valid = 1'b1; cmd_dma = dma; cmd_xfer = xfer;
    tick();
    cmd_valid = 1'b0; cmd_dma = 1'b0; cmd_xfer = 1'b0;
  endtask

  task automatic give_chunk(input logic [24:0] len, input logic short_buf);
    chunk_valid = 1'b1; chunk_len = len; chunk_short = short_buf;
    tick();
    chunk_valid = 1'b0; chunk_short = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count_rd", 32'(count_rd), 0);
    check("R1 dma_len", 32'(dma_len), 0);
    check("R1 flags", {27'd0, tc_status, dma_mode, xfer_busy, xfer_held, done_pulse}, 0);
  endtask

  task automatic t_load();
    wr_cnt(2'd0, 8'h34);
    check("R2 write leaves count_rd", 32'(count_rd), 0);
    wr_cnt(2'd1, 8'h12);
    wr_cnt(2'd2, 8'h00);
    send_cmd(1'b1, 1'b0);
    check("R3 reload", 32'(count_rd), 32'h1234);
    check("R3 dma_mode on", 32'(dma_mode), 1);
    send_cmd(1'b0, 1'b0);
    check("R3 dma_mode off", 32'(dma_mode), 0);
    check("R3 count_rd kept", 32'(count_rd), 32'h1234);
  endtask

  task automatic t_basic();
    dma_enable = 1'b1; pend_size = 25'sd100; capture_mode = 1'b0;
    send_cmd(1'b1, 1'b1);
    check("R5 grant by pending", 32'(dma_len), 100);
    check("R5 direction in", 32'(to_device), 0);
    check("R7 remaining", 32'(remaining), 100);
    check("R7 busy/tc", {30'd0, xfer_busy, tc_status}, 32'b10);
    give_chunk(25'd40, 1'b0);
    check("R8 decrement", 32'(remaining), 60);
    check("R8 no done yet", 32'(done_pulse), 0);
    give_chunk(25'd60, 1'b0);
    check("R9 done pulse", 32'(done_pulse), 1);
    check("R9 tc set", 32'(tc_status), 1);
    check("R9 count cleared", 32'(count_rd), 0);
    check("R9 idle", 32'(xfer_busy), 0);
    tick();
    check("R9 pulse one cycle", 32'(done_pulse), 0);
    wr_cnt(2'd0, 8'h05);
    check("R2 write clears tc", 32'(tc_status), 0);
  endtask

  task automatic t_zero_count();
    wr_cnt(2'd0, 8'h00); wr_cnt(2'd1, 8'h00); wr_cnt(2'd2, 8'h00);
    pend_size = -25'sd200000;
    send_cmd(1'b1, 1'b1);
    check("R4 zero means 65536", 32'(dma_len), 65536);
    check("R5 direction out", 32'(to_device), 1);
    give_chunk(25'd65536, 1'b0);
    check("R9 done after full", 32'(done_pulse), 1);
  endtask

  task automatic t_capture();
    capture_mode = 1'b1; pend_size = 25'sd5;
    wr_cnt(2'd0, 8'd80);
    send_cmd(1'b1, 1'b1);
    check("R6 capped at 32", 32'(dma_len), 32);
    give_chunk(25'd4, 1'b1);
    check("R10 remaining after short", 32'(remaining), 28);
    check("R10 done", 32'(done_pulse), 1);
    check("R10 tc/idle", {30'd0, tc_status, xfer_busy}, 32'b10);
    check("R10 count cleared", 32'(count_rd), 0);
    wr_cnt(2'd0, 8'd10);
    send_cmd(1'b1, 1'b1);
    check("R6 count below cap", 32'(dma_len), 10);
    give_chunk(25'd10, 1'b0);
    capture_mode = 1'b0;
  endtask

  task automatic t_held();
    dma_enable = 1'b0;
    wr_cnt(2'd0, 8'd20);
    pend_size = 25'sd7;
    send_cmd(1'b1, 1'b1);
    check("R11 held", {30'd0, xfer_held, xfer_busy}, 32'b10);
    check("R11 count reloaded", 32'(count_rd), 20);
    pend_size = 25'sd3;
    tick();
    check("R11 still held", 32'(xfer_held), 1);
    dma_enable = 1'b1;
    tick();
    check("R11 started on enable", {30'd0, xfer_held, xfer_busy}, 32'b01);
    check("R11 uses size at enable", 32'(dma_len), 3);
    give_chunk(25'd3, 1'b0);
  endtask

  task automatic t_no_dma();
    pend_size = 25'sd50;
    send_cmd(1'b0, 1'b1);
    check("R12 no start", 32'(xfer_busy), 0);
    check("R12 dma_len kept", 32'(dma_len), 3);
  endtask

  task automatic t_zero_grant();
    pend_size = 25'sd0;
    wr_cnt(2'd0, 8'd9);
    send_cmd(1'b1, 1'b1);
    check("R13 done at once", 32'(done_pulse), 1);
    check("R13 len zero", 32'(dma_len), 0);
    check("R13 tc/idle", {30'd0, tc_status, xfer_busy}, 32'b10);
  endtask

  initial begin
    rst_n = 1'b0; cnt_we = 0; cnt_sel = 0; cnt_wdata = 0;
    cmd_valid = 0; cmd_dma = 0; cmd_xfer = 0; pend_size = 0;
    capture_mode = 0; dma_enable = 0; chunk_valid = 0; chunk_len = 0; chunk_short = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_load();
    t_basic();
    t_zero_count();
    t_capture();
    t_held();
    t_no_dma();
    t_zero_grant();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule